// File: doc/BRIEF.md
# Frame-Synchronous Multichannel ADC Readout Sequencer

This block is the timing master for a delta-sigma converter that runs in frame-synchronous mode. After reset it pulls an active-low converter sync line low for a single master-clock cycle. It then starts a free-running frame. Each frame opens with a one-cycle frame strobe, followed by a serial-clock window of one word length. During that window, one serial data line is shifted in with the most significant bit first. The frame ends with an idle stretch that rounds it out to a fixed length of 2560 master clocks by default.

Conversions taken straight after the sync pulse are unreliable. The sequencer therefore lets a set number of frames pass before it raises a settled flag. From then on, every completed word is presented on a parallel bus together with a one-cycle valid pulse. All registers, including the one that captures the serial data bit, switch on the falling edge of the master clock. Every output transition is therefore launched from that edge.

Top module: `frame_readout_seq`

## Requirements
- R1: While reset is high, sync_n_o is 1, fsync_o, sclk_en_o, valid_o and settled_o are 0, and data_o is all zeros.
- R2: sync_n_o goes low at the first falling clock edge after reset is released and returns high at the next falling edge. It stays high after that.
- R3: fsync_o is high for one cycle starting at the falling edge that ends the sync pulse. It repeats every FRAME_LEN cycles after that (default 2560).
- R4: sclk_en_o is high for exactly WORD_W cycles (default 24), starting at the falling edge just after each strobe cycle. It is low at all other times, including strobe cycles.
- R5: The bit on dout_i during the i-th sclk_en_o cycle of a frame (i = 1..WORD_W) is sampled at the falling edge that ends that cycle. It becomes bit WORD_W-i of the word, so the first bit is the MSB.
- R6: valid_o pulses for one cycle starting at the falling edge that samples the last bit, which is WORD_W+1 cycles after the strobe. data_o carries the new word in that same cycle and otherwise holds its last value.
- R7: settled_o rises together with the strobe of frame SETTLE_FRAMES (frames counted from 0 after sync, default 128) and stays high. Before that, valid_o never pulses and data_o stays zero.
- R8: dout_i has no effect on any output outside the sclk_en_o windows.
- R9: Reset asserted at any point returns every output to the R1 state. Releasing it restarts the whole sequence: sync pulse, frame timing and the settling count.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state switches on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dout_i | input | 1 | Serial data from the converter |
| sync_n_o | output | 1 | Active-low converter sync pulse |
| fsync_o | output | 1 | One-cycle frame strobe |
| sclk_en_o | output | 1 | Serial clock enable, high during the capture window |
| data_o | output | WORD_W | Last settled sample |
| valid_o | output | 1 | One-cycle pulse marking a new word on data_o |
| settled_o | output | 1 | High once the settling frames have elapsed |

## Verification
The bench counts falling edges from the release of reset and samples every output at the rising edge midway between them. In that cycle the value launched by the preceding falling edge is stable. Using that count k, sync_n_o is due low at k=1 and the strobe at k=2+n·FRAME_LEN. sclk_en_o is due for the next WORD_W counts after each strobe, and valid_o with the word at count WORD_W+1 after the strobe. Each serial bit is driven at the rising edge after the count at which its window cycle opened, so the design samples it half a cycle later. Outside the windows the line is driven with random bits, so data_o shows any leakage.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        BOOT_IDLE,
        BOOT_PULSE,
        BOOT_RUN
    } boot_state_e;

    typedef struct packed {
        logic strobe;
        logic shift;
        logic last;
    } cap_ctrl_t;

    function automatic logic in_window(int unsigned pos, int unsigned width);
        return (pos >= 1) && (pos <= width);
    endfunction

endpackage

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import frs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic sync_n_o,
    output logic run_o
);

    boot_state_e state_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            state_q  <= BOOT_IDLE;
            sync_n_o <= 1'b1;
        end else begin
            unique case (state_q)
                BOOT_IDLE: begin
                    state_q  <= BOOT_PULSE;
                    sync_n_o <= 1'b0;
                end
                BOOT_PULSE: begin
                    state_q  <= BOOT_RUN;
                    sync_n_o <= 1'b1;
                end
                default: begin
                    state_q  <= BOOT_RUN;
                    sync_n_o <= 1'b1;
                end
            endcase
        end
    end

    assign run_o = (state_q != BOOT_IDLE);

endmodule

// File: rtl/frame_timer.sv
module frame_timer
    import frs_pkg::*;
#(
    parameter int unsigned FRAME_LEN     = 2560,
    parameter int unsigned WORD_W        = 24,
    parameter int unsigned SETTLE_FRAMES = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run_i,
    output cap_ctrl_t ctrl_o,
    output logic      settled_o
);

    localparam int unsigned CNT_W = $clog2(FRAME_LEN);
    localparam int unsigned SET_W = (SETTLE_FRAMES < 1) ? 1 : $clog2(SETTLE_FRAMES + 1);
    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] POS_WORD = CNT_W'(WORD_W);
    localparam logic [SET_W-1:0] SET_END  = SET_W'(SETTLE_FRAMES);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] pos_nxt;
    logic [SET_W-1:0] frames_q;
    logic             strobe_q;
    logic             shift_q;

    assign pos_nxt = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

    always_ff @(negedge clk) begin
        if (rst) begin
            pos_q     <= POS_LAST;
            strobe_q  <= 1'b0;
            shift_q   <= 1'b0;
            frames_q  <= '0;
            settled_o <= 1'b0;
        end else if (run_i) begin
            pos_q    <= pos_nxt;
            strobe_q <= (pos_nxt == '0);
            shift_q  <= in_window(int'(pos_nxt), WORD_W);
            if ((pos_nxt == '0) && !settled_o) begin
                if (frames_q == SET_END) begin
                    settled_o <= 1'b1;
                end else begin
                    frames_q <= frames_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        ctrl_o.strobe = strobe_q;
        ctrl_o.shift  = shift_q;
        ctrl_o.last   = shift_q && (pos_q == POS_WORD);
    end

endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import frs_pkg::*;
#(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  cap_ctrl_t         ctrl_i,
    input  logic              settled_i,
    input  logic              dout_i,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o
);

    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] shreg_nxt;

    assign shreg_nxt = {shreg_q[WORD_W-2:0], dout_i};

    always_ff @(negedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (ctrl_i.shift) begin
                shreg_q <= shreg_nxt;
            end
            if (ctrl_i.last && settled_i) begin
                data_o  <= shreg_nxt;
                valid_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_readout_seq.sv
module frame_readout_seq
    import frs_pkg::*;
#(
    parameter int unsigned FRAME_LEN     = 2560,
    parameter int unsigned WORD_W        = 24,
    parameter int unsigned SETTLE_FRAMES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dout_i,
    output logic              sync_n_o,
    output logic              fsync_o,
    output logic              sclk_en_o,
    output logic [WORD_W-1:0] data_o,
    output logic              valid_o,
    output logic              settled_o
);

    initial begin
        if (FRAME_LEN < WORD_W + 2) $error("frame too short for one word");
    end

    logic      run;
    cap_ctrl_t ctrl;

    sync_pulse_gen u_boot (
        .clk      (clk),
        .rst      (rst),
        .sync_n_o (sync_n_o),
        .run_o    (run)
    );

    frame_timer #(
        .FRAME_LEN     (FRAME_LEN),
        .WORD_W        (WORD_W),
        .SETTLE_FRAMES (SETTLE_FRAMES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .ctrl_o    (ctrl),
        .settled_o (settled_o)
    );

    word_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .ctrl_i    (ctrl),
        .settled_i (settled_o),
        .dout_i    (dout_i),
        .data_o    (data_o),
        .valid_o   (valid_o)
    );

    assign fsync_o   = ctrl.strobe;
    assign sclk_en_o = ctrl.shift;

endmodule

// File: rtl/frame_readout_seq_chk.sv
module frame_readout_seq_chk #(
    parameter int unsigned FRAME_LEN = 2560,
    parameter int unsigned WORD_W    = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_n,
    input logic              fsync,
    input logic              sclk_en,
    input logic              valid,
    input logic              settled,
    input logic [WORD_W-1:0] data
);

    localparam int unsigned GAP_W = $clog2(FRAME_LEN) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fsync) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_sync_single_r2: assert property (@(negedge clk) disable iff (rst)
        !sync_n |=> sync_n);

    p_fsync_single_r3: assert property (@(negedge clk) disable iff (rst)
        fsync |=> !fsync);

    p_frame_period_r3: assert property (@(negedge clk) disable iff (rst)
        (fsync && seen_q) |-> (gap_q == GAP_W'(FRAME_LEN - 1)));

    p_no_overlap_r4: assert property (@(negedge clk) disable iff (rst)
        !(fsync && sclk_en));

    p_valid_single_r6: assert property (@(negedge clk) disable iff (rst)
        valid |=> !valid);

    p_data_hold_r6: assert property (@(negedge clk) disable iff (rst)
        !valid |-> $stable(data));

    p_valid_after_settle_r7: assert property (@(negedge clk) disable iff (rst)
        valid |-> settled);

    p_settled_sticky_r7: assert property (@(negedge clk) disable iff (rst)
        settled |=> settled);

endmodule

bind frame_readout_seq frame_readout_seq_chk #(
    .FRAME_LEN (FRAME_LEN),
    .WORD_W    (WORD_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sync_n  (sync_n_o),
    .fsync   (fsync_o),
    .sclk_en (sclk_en_o),
    .valid   (valid_o),
    .settled (settled_o),
    .data    (data_o)
);

// File: tb/test_frame_readout_seq.sv
module test_frame_readout_seq;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 64;
    localparam int WORD_W     = 24;
    localparam int SETTLE     = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              dout = 1'b0;
    logic              sync_n, fsync, sclk_en, valid, settled;
    logic [WORD_W-1:0] data;

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] words [16];

    frame_readout_seq #(
        .FRAME_LEN     (FRAME_LEN),
        .WORD_W        (WORD_W),
        .SETTLE_FRAMES (SETTLE)
    ) i_frame_readout_seq (
        .clk       (clk),
        .rst       (rst),
        .dout_i    (dout),
        .sync_n_o  (sync_n),
        .fsync_o   (fsync),
        .sclk_en_o (sclk_en),
        .data_o    (data),
        .valid_o   (valid),
        .settled_o (settled)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [WORD_W-1:0] word_of(int frame);
        return words[frame % 16];
    endfunction

    task automatic fill_words();
        for (int i = 0; i < 16; i++) words[i] = WORD_W'($urandom);
        words[SETTLE]     = 24'hFFFFFF;
        words[SETTLE + 1] = 24'h800001;
        words[SETTLE + 2] = 24'h7FFFFF;
        words[SETTLE + 3] = 24'h000000;
    endtask

    task automatic check_reset_state(string req);
        check(req, "sync_n", 32'(sync_n), 1);
        check(req, "fsync", 32'(fsync), 0);
        check(req, "sclk_en", 32'(sclk_en), 0);
        check(req, "valid", 32'(valid), 0);
        check(req, "settled", 32'(settled), 0);
        check(req, "data", 32'(data), 0);
    endtask

    // k counts falling edges since reset release; sampled at the rising edge after edge k
    task automatic run_phase(int ncyc);
        logic [WORD_W-1:0] exp_data;
        exp_data = '0;
        for (int k = 1; k <= ncyc; k++) begin
            int j, pos, frame;
            logic e_fs, e_sc, e_va, e_se;
            @(posedge clk);
            j     = k - 2;
            pos   = (j >= 0) ? (j % FRAME_LEN) : -1;
            frame = (j >= 0) ? (j / FRAME_LEN) : -1;
            e_fs  = (pos == 0);
            e_sc  = (pos >= 1) && (pos <= WORD_W);
            e_se  = (frame >= SETTLE);
            e_va  = (pos == WORD_W + 1) && e_se;
            if (e_va) exp_data = word_of(frame);
            check("R2", "sync_n", 32'(sync_n), (k == 1) ? 0 : 1);
            check("R3", "fsync", 32'(fsync), 32'(e_fs));
            check("R4", "sclk_en", 32'(sclk_en), 32'(e_sc));
            check("R6", "valid", 32'(valid), 32'(e_va));
            check("R7", "settled", 32'(settled), 32'(e_se));
            // R5 word content and R8 immunity to bits driven outside the window
            check("R5_R8", "data", 32'(data), 32'(exp_data));
            if (e_sc) dout = word_of(frame)[WORD_W - pos];
            else      dout = 1'($urandom);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        fill_words();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        check_reset_state("R1");
        rst = 1'b0;
        // run into the capture window of a settled frame, then reset mid-capture
        run_phase(2 + (SETTLE + 4) * FRAME_LEN + 10);
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk);
            check_reset_state("R9");
        end
        fill_words();
        words[SETTLE] = 24'hA5C3F0;
        rst = 1'b0;
        // full restart: sync, settling count and capture repeat (R9)
        run_phase(2 + (SETTLE + 3) * FRAME_LEN);
        finish_sim();
    end

endmodule